// File: doc/BRIEF.md
# MAC Address Lookup Table Engine

This block holds a small table of 68-bit forwarding entries and searches it on request. Software never reaches the table storage directly. It fills three 32-bit staging words and then writes a table-control register. That write either commits the staged words to one index or asks for one index to be copied back into the staging words.

A lookup port takes a 48-bit destination address and walks the table one entry per clock. It returns a hit flag, the lowest matching index and the forwarding data of that entry. For a unicast entry the forwarding data is the egress port number. For a multicast entry it is the port mask. A second search mode ignores the key and returns the first free index, which is where the next new entry can go.

A global register enables lookups, holds a VLAN-aware flag for the datapath and starts a sweep that frees every entry. Each port has its own 2-bit forwarding state register, and these states are also brought out as a vector.

Top module: `addr_table_engine`

## Requirements
- R1: Register map by word address: 0 global, 1 table control, 2 to 4 staging words, 8 and up one register per port. A committed entry reads back through the staging words in this split: word 2 holds entry bits 31:0, word 3 holds bits 63:32, and word 4 holds bits 67:64 in its low 4 bits with zeros above. A table-control write with bit 31 set commits the staged words to the index in the low bits. A write with bit 31 clear loads that index into the staging words within four cycles.
- R2: After reset, and after a global write with bit 30 set, every entry becomes free (all 68 bits zero). Global bit 30 reads 1 while this sweep runs. The sweep takes one cycle per entry.
- R3: In address mode a lookup matches only entries whose type field (bits 61:60) is 1 or 3 and whose bits 47:0 equal the key. When several entries match, the lowest index is reported. Entries of type 0 or 2 never match.
- R4: When no entry matches, `lk_done` pulses with `lk_hit` low and `lk_index` zero.
- R5: On an address-mode hit, `lk_mcast` copies entry bit 40. `lk_fwd` is entry bits 67:66, which is the port number when bit 40 is clear and the port mask when it is set. `lk_kind` is entry bits 63:62.
- R6: In free mode the lookup returns the lowest index whose type is 0, and reports no hit when no entry is free. In this mode `lk_mcast`, `lk_fwd` and `lk_kind` are zero.
- R7: A start is ignored while global enable (bit 31) is low, while the clear sweep runs, or while a lookup is already busy.
- R8: `lk_done` is a one-cycle pulse and `lk_busy` is low when it fires. A hit at index i is reported at the (i+3)-th falling edge after the start is driven, and a miss at the (DEPTH+2)-th.
- R9: A port register keeps the low 2 bits written to it (0 disabled, 1 blocking, 2 learning, 3 forwarding) and reads zero above them. `port_state` carries port p in bits 2p+1:2p and changes only after a write.
- R10: The global register reads back enable in bit 31, the sweep flag in bit 30 and the VLAN-aware flag in bit 2, with all other bits zero. The VLAN-aware flag also drives `vlan_aware`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for `cfg_addr` |
| lk_start | input | 1 | Lookup request |
| lk_free_mode | input | 1 | 1: search for a free entry; 0: search for the key |
| lk_key | input | 48 | Destination address to look up |
| lk_busy | output | 1 | Lookup in progress |
| lk_done | output | 1 | One-cycle result strobe |
| lk_hit | output | 1 | Match found |
| lk_index | output | IDX_W | Lowest matching index |
| lk_mcast | output | 1 | Matched entry is multicast |
| lk_fwd | output | 2 | Port number or port mask |
| lk_kind | output | 2 | Unicast kind or multicast forwarding state |
| port_state | output | 2*NPORTS | Per-port forwarding states |
| vlan_aware | output | 1 | VLAN-aware flag |

## Verification
The assertions assume the host does not commit entries or start a new sweep while a lookup is running. They also assume the host does not request a readback in the same window as a lookup, because the read port is then shared and the results would depend on the interleaving. The stimulus meets these assumptions by running every register sequence to completion before the next lookup is started. The one exception is the deliberate case of a start issued during a clear sweep. Random entries draw their addresses from a small pool, so that duplicate keys, multicast keys and non-address entry types meet in the same table.

// File: rtl/aet_pkg.sv
package aet_pkg;
  localparam int ENTRY_W = 68;
  localparam int MAC_W   = 48;

  typedef enum logic [1:0] {
    ET_FREE      = 2'd0,
    ET_ADDR      = 2'd1,
    ET_VLAN      = 2'd2,
    ET_VLAN_ADDR = 2'd3
  } etype_e;

  localparam logic [3:0] RA_GLOBAL = 4'h0;
  localparam logic [3:0] RA_TBLCTL = 4'h1;
  localparam logic [3:0] RA_WORD_L = 4'h2;
  localparam logic [3:0] RA_WORD_M = 4'h3;
  localparam logic [3:0] RA_WORD_H = 4'h4;
  localparam logic [3:0] RA_PORT0  = 4'h8;

  localparam int GB_ENABLE = 31;
  localparam int GB_CLEAR  = 30;
  localparam int GB_VLAN   = 2;
  localparam int TC_COMMIT = 31;

  function automatic etype_e ent_type(input logic [ENTRY_W-1:0] e);
    return etype_e'(e[61:60]);
  endfunction

  function automatic logic [MAC_W-1:0] ent_mac(input logic [ENTRY_W-1:0] e);
    return e[47:0];
  endfunction

  function automatic logic ent_group(input logic [ENTRY_W-1:0] e);
    return e[40];
  endfunction

  function automatic logic [1:0] ent_fwd(input logic [ENTRY_W-1:0] e);
    return e[67:66];
  endfunction

  function automatic logic [1:0] ent_kind(input logic [ENTRY_W-1:0] e);
    return e[63:62];
  endfunction

  function automatic logic ent_is_addr(input logic [ENTRY_W-1:0] e);
    return (ent_type(e) == ET_ADDR) || (ent_type(e) == ET_VLAN_ADDR);
  endfunction
endpackage

// File: rtl/aet_table_ram.sv
module aet_table_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 68,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/aet_host_regs.sv
module aet_host_regs
  import aet_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NPORTS = 3,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [3:0]            cfg_addr,
  input  logic [31:0]           cfg_wdata,
  output logic [31:0]           cfg_rdata,
  output logic                  en,
  output logic                  vlan,
  output logic                  clr_busy,
  output logic [2*NPORTS-1:0]   port_state,
  output logic                  tw_en,
  output logic [IDX_W-1:0]      tw_idx,
  output logic [ENTRY_W-1:0]    tw_data,
  output logic                  rd_pend,
  output logic [IDX_W-1:0]      rd_idx,
  input  logic                  rd_serve,
  input  logic [ENTRY_W-1:0]    rd_q
);
  logic [3:0]       w_hi;
  logic [31:0]      w_mid;
  logic [31:0]      w_lo;
  logic             rd_issue;
  logic [IDX_W-1:0] clr_idx;
  logic [IDX_W-1:0] tbl_idx;
  logic [1:0]       pst [NPORTS];
  logic [31:0]      rd_mux;
  logic             wr_glob;
  logic             wr_tbl;
  logic             wr_commit;

  assign wr_glob   = cfg_we && (cfg_addr == RA_GLOBAL);
  assign wr_tbl    = cfg_we && (cfg_addr == RA_TBLCTL);
  assign wr_commit = wr_tbl && cfg_wdata[TC_COMMIT];

  // clear sweep owns the write port while it runs
  assign tw_en   = clr_busy || wr_commit;
  assign tw_idx  = clr_busy ? clr_idx : cfg_wdata[IDX_W-1:0];
  assign tw_data = clr_busy ? '0 : {w_hi, w_mid, w_lo};
  assign rd_idx  = tbl_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      vlan     <= 1'b0;
      clr_busy <= 1'b1;
      clr_idx  <= '0;
    end else begin
      if (clr_busy) begin
        clr_idx <= clr_idx + 1'b1;
        if (clr_idx == IDX_W'(DEPTH-1)) clr_busy <= 1'b0;
      end
      if (wr_glob) begin
        en   <= cfg_wdata[GB_ENABLE];
        vlan <= cfg_wdata[GB_VLAN];
        if (cfg_wdata[GB_CLEAR]) begin
          clr_busy <= 1'b1;
          clr_idx  <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_idx  <= '0;
      rd_pend  <= 1'b0;
      rd_issue <= 1'b0;
    end else begin
      rd_issue <= rd_serve;
      if (rd_serve) rd_pend <= 1'b0;
      if (wr_tbl) begin
        tbl_idx <= cfg_wdata[IDX_W-1:0];
        if (!cfg_wdata[TC_COMMIT]) rd_pend <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_hi  <= '0;
      w_mid <= '0;
      w_lo  <= '0;
    end else begin
      if (rd_issue) {w_hi, w_mid, w_lo} <= rd_q;
      if (cfg_we && cfg_addr == RA_WORD_H) w_hi  <= cfg_wdata[3:0];
      if (cfg_we && cfg_addr == RA_WORD_M) w_mid <= cfg_wdata;
      if (cfg_we && cfg_addr == RA_WORD_L) w_lo  <= cfg_wdata;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) pst[p] <= 2'd0;
      else if (cfg_we && cfg_addr == 4'(RA_PORT0 + p)) pst[p] <= cfg_wdata[1:0];
    end
    assign port_state[2*p +: 2] = pst[p];
  end

  always_comb begin
    rd_mux = '0;
    case (cfg_addr)
      RA_GLOBAL: begin
        rd_mux[GB_ENABLE] = en;
        rd_mux[GB_CLEAR]  = clr_busy;
        rd_mux[GB_VLAN]   = vlan;
      end
      RA_TBLCTL: rd_mux[IDX_W-1:0] = tbl_idx;
      RA_WORD_H: rd_mux[3:0] = w_hi;
      RA_WORD_M: rd_mux = w_mid;
      RA_WORD_L: rd_mux = w_lo;
      default:   rd_mux = '0;
    endcase
    for (int p = 0; p < NPORTS; p++) begin
      if (cfg_addr == 4'(RA_PORT0 + p)) rd_mux = {30'd0, pst[p]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_mux;
  end
endmodule

// File: rtl/aet_scan.sv
module aet_scan
  import aet_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               allow,
  input  logic               free_mode,
  input  logic [MAC_W-1:0]   key,
  input  logic [ENTRY_W-1:0] rdata,
  output logic [IDX_W-1:0]   raddr,
  output logic               busy,
  output logic               done,
  output logic               hit,
  output logic [IDX_W-1:0]   index,
  output logic               mcast,
  output logic [1:0]         fwd,
  output logic [1:0]         kind
);
  logic [IDX_W-1:0] iss_idx;
  logic             iss_end;
  logic             q_vld;
  logic [IDX_W-1:0] q_idx;
  logic             mode_q;
  logic [MAC_W-1:0] key_q;
  logic             match;
  logic             last;
  logic             finish;

  assign raddr = iss_idx;

  always_comb begin
    if (mode_q) match = (ent_type(rdata) == ET_FREE);
    else        match = ent_is_addr(rdata) && (ent_mac(rdata) == key_q);
    last   = (q_idx == IDX_W'(DEPTH-1));
    finish = busy && q_vld && (match || last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      hit     <= 1'b0;
      index   <= '0;
      mcast   <= 1'b0;
      fwd     <= '0;
      kind    <= '0;
      iss_idx <= '0;
      iss_end <= 1'b0;
      q_vld   <= 1'b0;
      q_idx   <= '0;
      mode_q  <= 1'b0;
      key_q   <= '0;
    end else begin
      done <= 1'b0;
      if (finish) begin
        busy  <= 1'b0;
        done  <= 1'b1;
        q_vld <= 1'b0;
        hit   <= match;
        index <= match ? q_idx : '0;
        mcast <= match && !mode_q && ent_group(rdata);
        fwd   <= (match && !mode_q) ? ent_fwd(rdata)  : 2'd0;
        kind  <= (match && !mode_q) ? ent_kind(rdata) : 2'd0;
      end else if (busy) begin
        if (!iss_end) begin
          q_vld <= 1'b1;
          q_idx <= iss_idx;
          if (iss_idx == IDX_W'(DEPTH-1)) iss_end <= 1'b1;
          else                            iss_idx <= iss_idx + 1'b1;
        end else begin
          q_vld <= 1'b0;
        end
      end else if (start && allow) begin
        busy    <= 1'b1;
        iss_idx <= '0;
        iss_end <= 1'b0;
        q_vld   <= 1'b0;
        key_q   <= key;
        mode_q  <= free_mode;
      end
    end
  end
endmodule

// File: rtl/addr_table_engine.sv
module addr_table_engine
  import aet_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NPORTS = 3,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [3:0]          cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic                lk_start,
  input  logic                lk_free_mode,
  input  logic [47:0]         lk_key,
  output logic                lk_busy,
  output logic                lk_done,
  output logic                lk_hit,
  output logic [IDX_W-1:0]    lk_index,
  output logic                lk_mcast,
  output logic [1:0]          lk_fwd,
  output logic [1:0]          lk_kind,
  output logic [2*NPORTS-1:0] port_state,
  output logic                vlan_aware
);
  logic               en_w;
  logic               clr_busy_w;
  logic               tw_en;
  logic [IDX_W-1:0]   tw_idx;
  logic [ENTRY_W-1:0] tw_data;
  logic               rd_pend;
  logic [IDX_W-1:0]   rd_idx;
  logic               rd_serve;
  logic [ENTRY_W-1:0] ram_q;
  logic [IDX_W-1:0]   ram_raddr;
  logic [IDX_W-1:0]   scan_raddr;
  logic               scan_busy;

  // the scanner owns the read port while busy; a readback waits for it
  assign rd_serve  = rd_pend && !scan_busy;
  assign ram_raddr = scan_busy ? scan_raddr : rd_idx;
  assign lk_busy   = scan_busy;

  aet_host_regs #(.DEPTH(DEPTH), .NPORTS(NPORTS)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .en(en_w), .vlan(vlan_aware), .clr_busy(clr_busy_w), .port_state(port_state),
    .tw_en(tw_en), .tw_idx(tw_idx), .tw_data(tw_data),
    .rd_pend(rd_pend), .rd_idx(rd_idx), .rd_serve(rd_serve), .rd_q(ram_q)
  );

  aet_table_ram #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_ram (
    .clk(clk), .we(tw_en), .waddr(tw_idx), .wdata(tw_data),
    .raddr(ram_raddr), .rdata(ram_q)
  );

  aet_scan #(.DEPTH(DEPTH)) u_scan (
    .clk(clk), .rst(rst),
    .start(lk_start), .allow(en_w && !clr_busy_w),
    .free_mode(lk_free_mode), .key(lk_key), .rdata(ram_q),
    .raddr(scan_raddr), .busy(scan_busy), .done(lk_done),
    .hit(lk_hit), .index(lk_index), .mcast(lk_mcast), .fwd(lk_fwd), .kind(lk_kind)
  );
endmodule

// File: rtl/aet_chk.sv
module aet_chk #(
  parameter int DEPTH  = 16,
  parameter int NPORTS = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                lk_busy,
  input logic                lk_done,
  input logic                lk_hit,
  input logic                cfg_we,
  input logic [2*NPORTS-1:0] port_state,
  input logic                en_w,
  input logic                clr_busy_w
);
  int busy_run;

  always_ff @(posedge clk) begin
    if (rst)          busy_run <= 0;
    else if (lk_busy) busy_run <= busy_run + 1;
    else              busy_run <= 0;
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    lk_done |=> !lk_done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    lk_done |-> !lk_busy);

  assert_busy_window_R8: assert property (@(posedge clk) disable iff (rst)
    busy_run <= DEPTH + 1);

  assert_accept_gate_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(lk_busy) |-> $past(en_w && !clr_busy_w));

  assert_hit_at_done_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(lk_hit) |-> lk_done);

  assert_port_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_we) |-> $stable(port_state));
endmodule

bind addr_table_engine aet_chk #(.DEPTH(DEPTH), .NPORTS(NPORTS)) u_chk (
  .clk(clk), .rst(rst), .lk_busy(lk_busy), .lk_done(lk_done), .lk_hit(lk_hit),
  .cfg_we(cfg_we), .port_state(port_state), .en_w(en_w), .clr_busy_w(clr_busy_w)
);

// File: tb/addr_table_engine_tb.sv
module addr_table_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int NPORTS = 3;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int WD_CYCLES = 100000;

  logic clk = 0;
  logic rst = 1;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic lk_start = 0;
  logic lk_free_mode = 0;
  logic [47:0] lk_key = 0;
  logic lk_busy, lk_done, lk_hit, lk_mcast;
  logic [IDX_W-1:0] lk_index;
  logic [1:0] lk_fwd, lk_kind;
  logic [2*NPORTS-1:0] port_state;
  logic vlan_aware;

  int checks = 0;
  int errors = 0;
  logic [67:0] mdl [DEPTH];
  logic [47:0] pool [4];

  // results of the last lookup
  logic r_hit, r_mcast;
  int r_idx, r_cyc;
  logic [1:0] r_fwd, r_kind;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_table_engine #(.DEPTH(DEPTH), .NPORTS(NPORTS)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .lk_start(lk_start), .lk_free_mode(lk_free_mode), .lk_key(lk_key),
    .lk_busy(lk_busy), .lk_done(lk_done), .lk_hit(lk_hit), .lk_index(lk_index),
    .lk_mcast(lk_mcast), .lk_fwd(lk_fwd), .lk_kind(lk_kind), .port_state(port_state),
    .vlan_aware(vlan_aware)
  );

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  function automatic logic [67:0] mk_entry(input logic [1:0] t, input logic [47:0] mac,
                                          input logic [1:0] kind, input logic [1:0] sb,
                                          input logic [1:0] fwd);
    return {fwd, sb, kind, t, 12'd0, mac};
  endfunction

  function automatic void model_lookup(input logic [47:0] key, input logic fm,
                                       output logic h, output int idx);
    h = 0;
    idx = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!h) begin
        if (fm ? (mdl[i][61:60] == 2'd0)
               : ((mdl[i][61:60] == 2'd1 || mdl[i][61:60] == 2'd3) && mdl[i][47:0] == key)) begin
          h = 1;
          idx = i;
        end
      end
    end
  endfunction

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic commit(input int idx, input logic [67:0] e);
    cfg_write(4'h4, {28'd0, e[67:64]});
    cfg_write(4'h3, e[63:32]);
    cfg_write(4'h2, e[31:0]);
    cfg_write(4'h1, 32'h8000_0000 | idx);
    mdl[idx] = e;
  endtask

  task automatic readback(input int idx, output logic [67:0] e);
    logic [31:0] a, b, c;
    cfg_write(4'h1, idx);
    repeat (4) @(negedge clk);
    cfg_read(4'h4, a);
    cfg_read(4'h3, b);
    cfg_read(4'h2, c);
    chk("R1 high word upper bits zero", a[31:4], 28'd0);
    e = {a[3:0], b, c};
  endtask

  task automatic wait_clear(output int cyc);
    logic [31:0] g;
    cyc = 0;
    cfg_read(4'h0, g);
    while (g[30] && cyc < 8*DEPTH) begin
      cyc++;
      cfg_read(4'h0, g);
    end
  endtask

  task automatic lookup(input logic [47:0] key, input logic fm);
    @(negedge clk);
    lk_start = 1; lk_key = key; lk_free_mode = fm;
    @(negedge clk);
    lk_start = 0;
    r_cyc = 1;
    while (!lk_done && r_cyc < DEPTH + 8) begin
      @(negedge clk);
      r_cyc++;
    end
    r_hit = lk_hit; r_idx = lk_index; r_mcast = lk_mcast; r_fwd = lk_fwd; r_kind = lk_kind;
  endtask

  task automatic try_start(input logic [47:0] key, input int n,
                           output logic saw_busy, output logic saw_done);
    saw_busy = 0; saw_done = 0;
    @(negedge clk);
    lk_start = 1; lk_key = key; lk_free_mode = 0;
    @(negedge clk);
    lk_start = 0;
    for (int i = 0; i < n; i++) begin
      if (lk_busy) saw_busy = 1;
      if (lk_done) saw_done = 1;
      @(negedge clk);
    end
  endtask

  task automatic check_lookup(input string tag, input logic [47:0] key, input logic fm);
    logic eh;
    int ei;
    model_lookup(key, fm, eh, ei);
    lookup(key, fm);
    chk({tag, " hit"}, r_hit, eh);
    chk({tag, " index"}, r_idx, ei);
    chk("R8 latency", r_cyc, eh ? ei + 3 : DEPTH + 2);
    if (eh && !fm) begin
      chk("R5 mcast", r_mcast, mdl[ei][40]);
      chk("R5 fwd", r_fwd, mdl[ei][67:66]);
      chk("R5 kind", r_kind, mdl[ei][63:62]);
    end else begin
      chk("R6 fields zero", {r_mcast, r_fwd, r_kind}, 5'd0);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] g;
    logic [67:0] e;
    logic [1:0] pv [NPORTS];
    logic sb, sd;
    int cyc, dones;
    void'($urandom(32'd4711));
    pool[0] = 48'h02_11_22_33_44_55;
    pool[1] = 48'h01_00_5e_00_00_07;
    pool[2] = 48'h00_aa_bb_cc_dd_ee;
    pool[3] = 48'h03_12_34_56_78_9a;
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;

    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R2 sweep flag after reset", cfg_rdata[30], 1'b1);
    chk("R8 reset busy", lk_busy, 1'b0);
    chk("R8 reset done", lk_done, 1'b0);
    chk("R9 reset port state", port_state, '0);
    wait_clear(cyc);
    chk("R2 sweep length bound", cyc <= DEPTH, 1'b1);
    readback(0, e);
    chk("R2 entry 0 free", e, 68'd0);
    readback(DEPTH-1, e);
    chk("R2 last entry free", e, 68'd0);

    // global register
    cfg_write(4'h0, 32'h8000_1004);
    cfg_read(4'h0, g);
    chk("R10 global readback", g, 32'h8000_0004);
    chk("R10 vlan output", vlan_aware, 1'b1);
    cfg_write(4'h0, 32'h8000_0000);
    chk("R10 vlan cleared", vlan_aware, 1'b0);

    // port registers
    for (int p = 0; p < NPORTS; p++) begin
      g = $urandom;
      pv[p] = g[1:0];
      cfg_write(4'(8 + p), g);
    end
    for (int p = 0; p < NPORTS; p++) begin
      cfg_read(4'(8 + p), g);
      chk("R9 port readback", g, {30'd0, pv[p]});
      chk("R9 port vector", port_state[2*p +: 2], pv[p]);
    end

    // directed address lookups
    commit(5, mk_entry(2'd1, pool[0], 2'd1, 2'b01, 2'd2));
    commit(9, mk_entry(2'd3, pool[0], 2'd0, 2'b00, 2'd1));
    commit(2, mk_entry(2'd2, pool[2], 2'd0, 2'b00, 2'd3));
    commit(12, mk_entry(2'd1, pool[1], 2'd3, 2'b00, 2'd3));
    check_lookup("R3 lowest duplicate", pool[0], 1'b0);
    chk("R3 duplicate at 5", r_idx, 5);
    check_lookup("R3 vlan-only type ignored", pool[2], 1'b0);
    chk("R4 miss", r_hit, 1'b0);
    check_lookup("R5 multicast", pool[1], 1'b0);
    chk("R5 mcast flag", r_mcast, 1'b1);
    check_lookup("R4 absent key", 48'h0a_0b_0c_0d_0e_0f, 1'b0);
    readback(12, e);
    chk("R1 readback 12", e, mdl[12]);
    readback(9, e);
    chk("R1 readback 9", e, mdl[9]);

    // free search
    check_lookup("R6 first free", 48'd0, 1'b1);
    chk("R6 first free is 0", r_idx, 0);
    for (int i = 0; i < DEPTH; i++)
      if (mdl[i][61:60] == 2'd0) commit(i, mk_entry(2'd2, 48'd0, 2'd0, 2'b00, 2'd0));
    check_lookup("R6 full table", 48'd0, 1'b1);
    commit(DEPTH-1, 68'd0);
    check_lookup("R6 only last free", 48'd0, 1'b1);

    // random traffic
    for (int it = 0; it < 60; it++) begin
      logic [47:0] k;
      int ix;
      ix = $urandom_range(0, DEPTH-1);
      k = pool[$urandom_range(0, 3)];
      commit(ix, mk_entry(2'($urandom_range(0, 3)), k, 2'($urandom), 2'($urandom), 2'($urandom)));
      if ($urandom_range(0, 4) == 0) check_lookup("R6 random free", 48'd0, 1'b1);
      else if ($urandom_range(0, 5) == 0) check_lookup("R3 random key", {$urandom, 16'h0}, 1'b0);
      else check_lookup("R3 random pool", pool[$urandom_range(0, 3)], 1'b0);
      if (it % 10 == 0) begin
        readback(ix, e);
        chk("R1 random readback", e, mdl[ix]);
      end
    end

    // start while disabled
    cfg_write(4'h0, 32'h0000_0000);
    try_start(pool[0], DEPTH + 4, sb, sd);
    chk("R7 disabled no busy", sb, 1'b0);
    chk("R7 disabled no done", sd, 1'b0);

    // clear with a start during the sweep
    cfg_write(4'h0, 32'hC000_0000);
    try_start(pool[0], 3, sb, sd);
    chk("R7 clearing no busy", sb, 1'b0);
    chk("R7 clearing no done", sd, 1'b0);
    wait_clear(cyc);
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    readback(7, e);
    chk("R2 cleared entry", e, 68'd0);
    check_lookup("R2 free after clear", 48'd0, 1'b1);
    chk("R2 free index 0", r_idx, 0);

    // second start while busy is ignored
    commit(10, mk_entry(2'd1, pool[3], 2'd2, 2'b10, 2'd1));
    commit(1, mk_entry(2'd1, pool[2], 2'd0, 2'b00, 2'd0));
    @(negedge clk);
    lk_start = 1; lk_key = pool[3]; lk_free_mode = 0;
    @(negedge clk);
    lk_key = pool[2];
    @(negedge clk);
    lk_start = 0;
    dones = 0;
    for (int i = 0; i < DEPTH + 6; i++) begin
      if (lk_done) begin
        dones++;
        r_idx = lk_index;
      end
      @(negedge clk);
    end
    chk("R7 single result while busy", dones, 1);
    chk("R7 first key kept", r_idx, 10);

    summary();
    $finish;
  end
endmodule